// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block sits beside a two-port shared memory of 8K words and watches the access strobes of both ports. It drives one interrupt flag toward each port. The two highest word addresses serve as mailboxes. The topmost word is the right port's inbox, and the word just below it is the left port's inbox.

When one port writes its partner's inbox, the partner's flag goes active. When the partner later reads that inbox word, its flag returns inactive. The mailbox words live in the shared array like any other location, and their contents mean whatever software decides. This block only observes the accesses; it stores no data.

Both flags are registered and active low, and each is driven at both levels. An access sampled on one clock edge shows up on the flags directly after that edge. Access strobes are active-high enables on a synchronous fabric.

Top module: `mbx_irq`

## Requirements
- R1: While reset is high, and on the first edge after it, both `l_irq_n` and `r_irq_n` are 1.
- R2: A left write (`l_en`=1, `l_rnw`=0) to address 0x1FFF drives `r_irq_n` to 0 after the edge that samples it.
- R3: A right read (`r_en`=1, `r_rnw`=1, `r_oe`=1) of address 0x1FFF drives `r_irq_n` to 1 after the sampling edge, unless R7 applies.
- R4: A right write to address 0x1FFE drives `l_irq_n` to 0 after the sampling edge.
- R5: A left read of address 0x1FFE drives `l_irq_n` to 1 after the sampling edge, unless R7 applies.
- R6: A read only counts when enable, output enable and `rnw`=1 are all present. A write only counts when enable is 1 and `rnw`=0. Any other strobe combination leaves both flags unchanged.
- R7: When a set and a clear of the same flag are sampled on the same edge, the flag becomes or stays 0.
- R8: These accesses leave both flags unchanged: a port writing its own inbox, a port reading its partner's inbox, and any access to an address below 0x1FFE.
- R9: With no qualifying event, a flag holds its level. A second set of a flag that is already active keeps it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_en | input | 1 | Left port enable |
| l_rnw | input | 1 | Left direction: 1 = read, 0 = write |
| l_oe | input | 1 | Left output enable |
| l_addr | input | 13 | Left word address |
| r_en | input | 1 | Right port enable |
| r_rnw | input | 1 | Right direction: 1 = read, 0 = write |
| r_oe | input | 1 | Right output enable |
| r_addr | input | 13 | Right word address |
| l_irq_n | output | 1 | Left interrupt flag, active low |
| r_irq_n | output | 1 | Right interrupt flag, active low |

## Verification
The bench sweeps every combination of enable, direction and output enable on each port, crossed with both mailbox addresses and two ordinary addresses. It starts from both flag levels, so a design that counts a write without its enable, or a read without output enable, is caught. The same sweep catches a design that lets a port's own inbox write or a read of the partner's inbox disturb a flag. A dedicated cycle issues a set and a clear of the same flag together; a design that favours the clear would drop a message, and the bench would see the flag high. Flags are also checked across idle cycles and repeated sets, which exposes flags that pulse instead of holding.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Per-flag event pair produced from the two ports' decoded accesses
  typedef struct packed {
    logic set;
    logic clr;
  } flag_evt_t;

  function automatic logic is_wr(input logic en, input logic rnw);
    return en & ~rnw;
  endfunction

  function automatic logic is_rd(input logic en, input logic rnw, input logic oe);
    return en & rnw & oe;
  endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] OWN_BOX = '1,
  parameter logic [ADDR_W-1:0] PEER_BOX = '0
) (
  input  logic              en,
  input  logic              rnw,
  input  logic              oe,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_peer,
  output logic              rd_own
);

  logic hit_own;
  logic hit_peer;

  always_comb begin
    hit_own  = (addr == OWN_BOX);
    hit_peer = (addr == PEER_BOX);
    wr_peer  = is_wr(en, rnw) & hit_peer;
    rd_own   = is_rd(en, rnw, oe) & hit_own;
  end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag
  import mbx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  flag_evt_t evt,
  output logic      irq_n
);

  always_ff @(posedge clk) begin
    if (rst)          irq_n <= 1'b1;
    else if (evt.set) irq_n <= 1'b0;
    else if (evt.clr) irq_n <= 1'b1;
  end

  // R1
  flag_rst_chk: assert property (@(posedge clk) rst |=> irq_n);

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    evt.set |=> !irq_n);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!evt.set && !evt.clr) |=> $stable(irq_n));

endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_en,
  input  logic              l_rnw,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en,
  input  logic              r_rnw,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_irq_n,
  output logic              r_irq_n
);

  localparam int NSIDE = 2;
  localparam logic [ADDR_W-1:0] R_BOX = '1;
  localparam logic [ADDR_W-1:0] L_BOX = R_BOX - 1'b1;

  logic [NSIDE-1:0] en_a, rnw_a, oe_a;
  logic [ADDR_W-1:0] addr_a [NSIDE];
  logic [NSIDE-1:0] wr_peer, rd_own, irq_a;
  flag_evt_t evt_a [NSIDE];

  always_comb begin
    en_a      = {r_en, l_en};
    rnw_a     = {r_rnw, l_rnw};
    oe_a      = {r_oe, l_oe};
    addr_a[0] = l_addr;
    addr_a[1] = r_addr;
  end

  // side 0 = left (inbox L_BOX), side 1 = right (inbox R_BOX)
  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    localparam logic [ADDR_W-1:0] OWN  = (s == 0) ? L_BOX : R_BOX;
    localparam logic [ADDR_W-1:0] PEER = (s == 0) ? R_BOX : L_BOX;

    mbx_port_decode #(.ADDR_W(ADDR_W), .OWN_BOX(OWN), .PEER_BOX(PEER)) u_dec (
      .en      (en_a[s]),
      .rnw     (rnw_a[s]),
      .oe      (oe_a[s]),
      .addr    (addr_a[s]),
      .wr_peer (wr_peer[s]),
      .rd_own  (rd_own[s])
    );

    always_comb begin
      evt_a[s].set = wr_peer[NSIDE-1-s];
      evt_a[s].clr = rd_own[s];
    end

    mbx_flag u_flag (
      .clk   (clk),
      .rst   (rst),
      .evt   (evt_a[s]),
      .irq_n (irq_a[s])
    );
  end

  assign l_irq_n = irq_a[0];
  assign r_irq_n = irq_a[1];

  // R2
  l_sets_r_chk: assert property (@(posedge clk) disable iff (rst)
    (l_en && !l_rnw && l_addr == R_BOX) |=> !r_irq_n);

  // R4
  r_sets_l_chk: assert property (@(posedge clk) disable iff (rst)
    (r_en && !r_rnw && r_addr == L_BOX) |=> !l_irq_n);

  // R3
  r_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (r_en && r_rnw && r_oe && r_addr == R_BOX &&
     !(l_en && !l_rnw && l_addr == R_BOX)) |=> r_irq_n);

  // R5
  l_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (l_en && l_rnw && l_oe && l_addr == L_BOX &&
     !(r_en && !r_rnw && r_addr == L_BOX)) |=> l_irq_n);

  // R6
  idle_ports_chk: assert property (@(posedge clk) disable iff (rst)
    (!l_en && !r_en) |=> ($stable(l_irq_n) && $stable(r_irq_n)));

  // R8
  own_box_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (l_en && !l_rnw && l_addr == L_BOX && !r_en) |=>
    ($stable(l_irq_n) && $stable(r_irq_n)));

endmodule

// File: tb/sim_mbx_irq.sv
module sim_mbx_irq;

  localparam int AW = 13;
  localparam logic [AW-1:0] RB = 13'h1FFF;
  localparam logic [AW-1:0] LB = 13'h1FFE;

  logic clk = 1'b0;
  logic rst;
  logic l_en, l_rnw, l_oe, r_en, r_rnw, r_oe;
  logic [AW-1:0] l_addr, r_addr;
  logic l_irq_n, r_irq_n;

  int checks = 0;
  int errors = 0;
  logic exp_l, exp_r;

  always #10 clk = ~clk;

  mbx_irq #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst),
    .l_en(l_en), .l_rnw(l_rnw), .l_oe(l_oe), .l_addr(l_addr),
    .r_en(r_en), .r_rnw(r_rnw), .r_oe(r_oe), .r_addr(r_addr),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge (current), compute expected from the requirements,
  // sample at the following negedge
  task automatic step(input logic le, input logic lr, input logic lo, input logic [AW-1:0] la,
                      input logic re, input logic rr, input logic ro, input logic [AW-1:0] ra,
                      input string tag);
    logic lw, lrd, rw, rrd;
    l_en = le; l_rnw = lr; l_oe = lo; l_addr = la;
    r_en = re; r_rnw = rr; r_oe = ro; r_addr = ra;
    lw  = le && !lr;      rw  = re && !rr;
    lrd = le && lr && lo; rrd = re && rr && ro;
    if (lw && la == RB)       exp_r = 1'b0;
    else if (rrd && ra == RB) exp_r = 1'b1;
    if (rw && ra == LB)       exp_l = 1'b0;
    else if (lrd && la == LB) exp_l = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(tag, l_irq_n, exp_l, "l_irq_n");
    chk(tag, r_irq_n, exp_r, "r_irq_n");
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b1, 1'b0, '0, tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] addrs [4];
    addrs[0] = RB; addrs[1] = LB; addrs[2] = 13'h0000; addrs[3] = 13'h1FFD;
    rst = 1'b1;
    l_en = 0; l_rnw = 1; l_oe = 0; l_addr = '0;
    r_en = 0; r_rnw = 1; r_oe = 0; r_addr = '0;
    exp_l = 1'b1; exp_r = 1'b1;
    @(negedge clk);
    // R1: reset state, even with a set presented during reset
    l_en = 1; l_rnw = 0; l_addr = RB;
    @(posedge clk); @(negedge clk);
    chk("R1", l_irq_n, 1'b1, "l_irq_n in reset");
    chk("R1", r_irq_n, 1'b1, "r_irq_n in reset");
    rst = 1'b0;
    idle("R1");

    // R2 / R3
    step(1, 0, 0, RB, 0, 1, 0, '0, "R2");
    idle("R9");
    step(1, 0, 0, RB, 0, 1, 0, '0, "R9");
    step(0, 1, 0, '0, 1, 1, 1, RB, "R3");
    // R4 / R5
    step(0, 1, 0, '0, 1, 0, 0, LB, "R4");
    idle("R9");
    step(1, 1, 1, LB, 0, 1, 0, '0, "R5");
    // R7: set and clear of the same flag together
    step(1, 0, 0, RB, 1, 1, 1, RB, "R7");
    step(1, 1, 1, LB, 1, 0, 0, LB, "R7");
    step(1, 1, 1, LB, 1, 1, 1, RB, "R3");
    // R8: own inbox write and peer inbox read
    step(1, 0, 0, LB, 0, 1, 0, '0, "R8");
    step(0, 1, 0, '0, 1, 1, 1, LB, "R8");

    // R6 / R8 sweep: every strobe combination on each side, each address,
    // from both flag levels
    for (int side = 0; side < 2; side++) begin
      for (int c = 0; c < 8; c++) begin
        for (int a = 0; a < 4; a++) begin
          if (((c + a) % 2) == 1)
            step(1, 0, 0, RB, 1, 0, 0, LB, "R6 prime");
          else begin
            step(0, 1, 0, '0, 1, 1, 1, RB, "R6 prime");
            step(1, 1, 1, LB, 0, 1, 0, '0, "R6 prime");
          end
          if (side == 0)
            step(c[2], c[1], c[0], addrs[a], 0, 1, 0, '0, "R6 R8 left");
          else
            step(0, 1, 0, '0, c[2], c[1], c[0], addrs[a], "R6 R8 right");
        end
      end
    end

    idle("R9");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule